// File: doc/BRIEF.md
# Voltage-ID Command Receiver

This block accepts a 6-bit supply voltage request from a processor over a four-wire parallel link. The link has three data lines and one select strobe. While the strobe is low, the data lines carry the three low bits of the code. While it is high, they carry the three high bits. The block deglitches all four wires and keeps the last low half it saw. On the rising edge of the filtered strobe it joins the two halves into a new target.

A second mode suits processors that send only 4-bit codes. In that mode the code is built from one bit sent during the strobe-low phase and the three data bits present at the rising edge. This 4-bit value is placed on the upper part of the 6-bit scale.

The block does not jump to a new target. It moves an internal code toward the target one step at a time, with a fixed minimum spacing between steps. The code it drives to the current DAC is inverted, so a higher request gives a smaller current. At reset, a 4-bit strap selects the start level. That level becomes both the target and the current code until the first command arrives.

Top module: `vid_cmd_rx`

## Requirements
- R1: While `rst` is high at a clock edge, the current code and the target both load the preset `{strap_i, 2'b00}`. As a result `dac_code_o` = 63 − 4·strap, `settled_o` = 1 and `cmd_seen_o` = 0.
- R2: In 6-bit mode (`mode4_i` = 0), the data value held while the strobe is low becomes bits [2:0] of the target. The data value present when the strobe rises becomes bits [5:3]. The target is updated only on the rising edge of the filtered strobe.
- R3: In 4-bit mode (`mode4_i` = 1), the target is formed on the rising strobe edge as {data at the rising edge, bit 0 of the strobe-low data, 2'b00}.
- R4: `dac_code_o` always equals 63 minus the current code. Code 0 therefore gives 63, and code 63 gives 0.
- R5: A level change on the strobe or on any data line that lasts fewer than `STABLE` cycles (default 8) is ignored. Such a pulse neither commits a command nor alters the captured half.
- R6: The current code changes by exactly one per step. Consecutive steps are at least `RATE_DIV` cycles apart (default 4). The code reaches the target and stops there.
- R7: `settled_o` is 1 exactly when the current code equals the target. While it is 1, the current code does not change.
- R8: `cmd_seen_o` rises at the first commit after reset. It then stays high until the next reset.
- R9: Changing `strap_i` while `rst` is low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_data_i | input | 3 | Code half carried on the link |
| vid_sel_i | input | 1 | Half select strobe; its rising edge commits the command |
| mode4_i | input | 1 | 1 selects 4-bit command mode |
| strap_i | input | 4 | Power-up preset select |
| dac_code_o | output | 6 | Inverted current code sent to the current DAC |
| settled_o | output | 1 | Current code has reached the target |
| cmd_seen_o | output | 1 | At least one command has been committed since reset |

## Verification
Two cases are hardest to reach from the ports. The first is a glitch that is long enough to pass the synchronizer but shorter than the filter window. The second is a glitch on a data line during the low phase, which should leave the captured half unchanged. The bench drives pulses of a few cycles on the strobe alone, and separately on the data lines between a stable low half and the commit. It then checks that the committed code keeps the original half. A cycle-by-cycle monitor observes every change of `dac_code_o` during random full-scale ramps. It checks the step size and the spacing between steps, including when a new target reverses the ramp.

// File: rtl/vid_pkg.sv
package vid_pkg;

    localparam int VID_W   = 6;
    localparam int HALF_W  = 3;
    localparam int STRAP_W = 4;
    localparam int LINK_W  = HALF_W + 1;

    typedef logic [VID_W-1:0]   vid_t;
    typedef logic [HALF_W-1:0]  half_t;
    typedef logic [STRAP_W-1:0] strap_t;

    typedef enum logic {
        MODE_SIX  = 1'b0,
        MODE_FOUR = 1'b1
    } vid_mode_e;

    typedef struct packed {
        logic  sel;
        half_t data;
    } link_t;

    localparam vid_t VID_TOP = '1;

    function automatic vid_t strap_to_vid(input strap_t s);
        return {s, {(VID_W-STRAP_W){1'b0}}};
    endfunction

    function automatic vid_t join_halves(input vid_mode_e m, input half_t lo, input half_t hi);
        vid_t v;
        if (m == MODE_FOUR)
            v = {hi, lo[0], 2'b00};
        else
            v = {hi, lo};
        return v;
    endfunction

    function automatic vid_t to_dac(input vid_t v);
        return VID_TOP - v;
    endfunction

endpackage

// File: rtl/vid_deglitch.sv
module vid_deglitch #(
    parameter int STABLE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = (STABLE > 2) ? $clog2(STABLE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE - 1);

    logic             meta_q;
    logic             sync_q;
    logic             clean_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= 1'b0;
            sync_q  <= 1'b0;
            clean_q <= 1'b0;
            run_q   <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q == clean_q) begin
                run_q <= '0;
            end else if (run_q == CNT_LAST) begin
                clean_q <= sync_q;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign clean_o = clean_q;

    AST_DG_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
        (clean_q != $past(clean_q)) |-> (clean_q == $past(sync_q))); // R5

endmodule

// File: rtl/vid_assemble.sv
module vid_assemble
    import vid_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vid_mode_e mode_i,
    input  link_t     link_i,
    input  vid_t      preset_i,
    output vid_t      target_o,
    output logic      seen_o
);
    half_t lo_q;
    logic  sel_q;
    vid_t  target_q;
    logic  seen_q;
    logic  rise;

    assign rise = link_i.sel && !sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q     <= '0;
            sel_q    <= 1'b0;
            target_q <= preset_i;
            seen_q   <= 1'b0;
        end else begin
            sel_q <= link_i.sel;
            if (!link_i.sel)
                lo_q <= link_i.data;
            if (rise) begin
                target_q <= join_halves(mode_i, lo_q, link_i.data);
                seen_q   <= 1'b1;
            end
        end
    end

    assign target_o = target_q;
    assign seen_o   = seen_q;

    AST_TGT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (target_q != $past(target_q)) |-> $past(rise)); // R2

    AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (rst)
        seen_q |=> seen_q); // R8

endmodule

// File: rtl/vid_slew.sv
module vid_slew
    import vid_pkg::*;
#(
    parameter int RATE_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  vid_t preset_i,
    input  vid_t target_i,
    output vid_t level_o,
    output logic settled_o
);
    localparam int TW = (RATE_DIV > 2) ? $clog2(RATE_DIV) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(RATE_DIV - 1);

    vid_t          level_q;
    logic [TW-1:0] tick_q;
    logic          at_target;

    assign at_target = (level_q == target_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= preset_i;
            tick_q  <= '0;
        end else if (at_target) begin
            tick_q <= '0;
        end else if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            if (target_i > level_q)
                level_q <= level_q + 1'b1;
            else
                level_q <= level_q - 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign level_o   = level_q;
    assign settled_o = at_target;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + 6'd1)
                 || (level_q == $past(level_q) - 6'd1)); // R6

    AST_SETTLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        at_target |=> $stable(level_q)); // R7

endmodule

// File: rtl/vid_cmd_rx.sv
module vid_cmd_rx
    import vid_pkg::*;
#(
    parameter int STABLE   = 8,
    parameter int RATE_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] vid_data_i,
    input  logic       vid_sel_i,
    input  logic       mode4_i,
    input  logic [3:0] strap_i,
    output logic [5:0] dac_code_o,
    output logic       settled_o,
    output logic       cmd_seen_o
);
    link_t     raw_link;
    link_t     clean_link;
    vid_t      preset;
    vid_t      target;
    vid_t      level;
    vid_mode_e mode;

    assign raw_link = '{sel: vid_sel_i, data: vid_data_i};
    assign preset   = strap_to_vid(strap_i);
    assign mode     = mode4_i ? MODE_FOUR : MODE_SIX;

    for (genvar i = 0; i < LINK_W; i++) begin : g_filt
        vid_deglitch #(.STABLE(STABLE)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_link[i]),
            .clean_o(clean_link[i])
        );
    end

    vid_assemble u_asm (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode),
        .link_i  (clean_link),
        .preset_i(preset),
        .target_o(target),
        .seen_o  (cmd_seen_o)
    );

    vid_slew #(.RATE_DIV(RATE_DIV)) u_slew (
        .clk      (clk),
        .rst      (rst),
        .preset_i (preset),
        .target_i (target),
        .level_o  (level),
        .settled_o(settled_o)
    );

    assign dac_code_o = to_dac(level);

endmodule

// File: tb/vid_cmd_rx_test.sv
module vid_cmd_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int RATE_DIV   = 4;
    localparam int SETTLE     = 320;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] vid_data_i = '0;
    logic       vid_sel_i = 1'b0;
    logic       mode4_i = 1'b0;
    logic [3:0] strap_i = 4'b1010;
    logic [5:0] dac_code_o;
    logic       settled_o;
    logic       cmd_seen_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    vid_cmd_rx #(.STABLE(8), .RATE_DIV(RATE_DIV)) uut (
        .clk(clk), .rst(rst), .vid_data_i(vid_data_i), .vid_sel_i(vid_sel_i),
        .mode4_i(mode4_i), .strap_i(strap_i), .dac_code_o(dac_code_o),
        .settled_o(settled_o), .cmd_seen_o(cmd_seen_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_six(input int lo, input int hi);
        return (hi % 8) * 8 + (lo % 8);
    endfunction

    function automatic int exp_four(input int lo, input int hi);
        return (hi % 8) * 8 + (lo % 2) * 4;
    endfunction

    function automatic int exp_dac(input int v);
        return 63 - v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Step-size and spacing monitor: R6
    int   gap  = 1000;
    logic [5:0] prev = '0;
    always @(posedge clk) begin
        #2;
        if (rst) begin
            gap  = 1000;
            prev = dac_code_o;
        end else if (dac_code_o != prev) begin
            check("R6 step size", (dac_code_o > prev) ? dac_code_o - prev : prev - dac_code_o, 1);
            check("R6 step spacing", (gap + 1 >= RATE_DIV) ? 1 : 0, 1);
            gap  = 0;
            prev = dac_code_o;
        end else begin
            gap = gap + 1;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int lo, input int hi);
        vid_sel_i  = 1'b0;
        vid_data_i = 3'(lo);
        cyc(20);
        vid_data_i = 3'(hi);
        vid_sel_i  = 1'b1;
    endtask

    task automatic do_reset(input logic [3:0] s);
        strap_i = s;
        rst = 1'b1;
        cyc(4);
        rst = 1'b0;
        cyc(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset(4'b1010);
        check("R1 reset dac", dac_code_o, exp_dac(40));
        check("R7 settled at reset", settled_o, 1);
        check("R8 no command at reset", cmd_seen_o, 0);

        strap_i = 4'b0011;
        cyc(30);
        check("R9 strap ignored", dac_code_o, exp_dac(40));

        // Short strobe pulse: R5
        vid_data_i = 3'b101;
        cyc(20);
        vid_sel_i = 1'b1;
        cyc(5);
        vid_sel_i = 1'b0;
        cyc(40);
        check("R5 strobe glitch no commit", dac_code_o, exp_dac(40));
        check("R5 strobe glitch no flag", cmd_seen_o, 0);

        // Directed 6-bit command
        send(5, 7);
        cyc(35);
        check("R7 ramping not settled", settled_o, 0);
        check("R8 flag after commit", cmd_seen_o, 1);
        cyc(SETTLE);
        check("R2 six-bit assemble", dac_code_o, exp_dac(exp_six(5, 7)));
        check("R7 settled after ramp", settled_o, 1);

        send(0, 0);
        cyc(SETTLE);
        check("R4 code zero full scale", dac_code_o, 63);
        send(7, 7);
        cyc(SETTLE);
        check("R4 code 63 zero drive", dac_code_o, 0);

        // Data glitch during low phase: R5
        vid_sel_i  = 1'b0;
        vid_data_i = 3'b010;
        cyc(20);
        vid_data_i = 3'b101;
        cyc(5);
        vid_data_i = 3'b010;
        cyc(20);
        vid_data_i = 3'b100;
        vid_sel_i  = 1'b1;
        cyc(SETTLE);
        check("R5 data glitch ignored", dac_code_o, exp_dac(exp_six(2, 4)));

        // Directed 4-bit command
        mode4_i = 1'b1;
        send(3, 6);
        cyc(SETTLE);
        check("R3 four-bit assemble", dac_code_o, exp_dac(exp_four(3, 6)));
        mode4_i = 1'b0;

        // Random commands, reversal mid-ramp included
        for (int k = 0; k < 24; k++) begin
            int lo, hi, m;
            lo = int'($urandom_range(0, 7));
            hi = int'($urandom_range(0, 7));
            m  = int'($urandom_range(0, 1));
            mode4_i = m[0];
            send(lo, hi);
            if (k % 6 == 5) begin
                cyc(60);
                lo = int'($urandom_range(0, 7));
                hi = int'($urandom_range(0, 7));
                send(lo, hi);
            end
            cyc(SETTLE);
            v = (m == 1) ? exp_four(lo, hi) : exp_six(lo, hi);
            check(m == 1 ? "R3 random four-bit" : "R2 random six-bit", dac_code_o, exp_dac(v));
            check("R7 random settled", settled_o, 1);
        end
        mode4_i = 1'b0;

        // Reset mid-operation reloads the preset
        vid_sel_i = 1'b0;
        do_reset(4'b0011);
        check("R1 reset reload", dac_code_o, exp_dac(12));
        check("R8 flag cleared", cmd_seen_o, 0);
        cyc(5);
        finish_run();
    end

endmodule